// File: doc/BRIEF.md
# Packed BAR Region Decoder and Window Translator

This block sits behind one host-facing endpoint of a two-host bridge. Each host access arrives as a BAR number and a byte offset within that BAR. The block works out which bridge region the access targets and reports a region code with an offset local to that region. Several regions share one BAR, and the split points inside a BAR are set at runtime.

In BAR0, configuration space comes first and this host's own scratchpad follows it. BAR1 is an alias of the scratchpad that the other host owns. In BAR2, the doorbell area comes first and memory window 1 follows it. BARs 3, 4 and 5 each carry one further memory window. For an access that lands in a memory window, the block forms a 64-bit outbound address from that window's programmed base. It delivers this address on a registered output one cycle after the request.

Anything that falls outside an allowed region is refused with an error flag. This covers scratchpad slots beyond the count, window offsets beyond the window size, windows that are unconfigured or not built, and BAR numbers above 5. A refused access produces no translation.

Top module: `nbr_bar_xlate`

## Requirements
- R1: With `req_valid` high, a BAR0 access below `spad_off` returns region code 1 (config) with a local offset equal to the request offset. No error is raised.
- R2: A BAR0 access at or above `spad_off` returns region code 2 (own scratchpad) with local offset `req_off - spad_off` while that difference is below `4*spad_count`. Otherwise it is an error.
- R3: A BAR1 access returns region code 3 (the other host's scratchpad) with local offset `req_off` while `req_off` is below `4*spad_count`. Otherwise it is an error.
- R4: A BAR2 access below `mw1_off` returns region code 4 (doorbell) with local offset `req_off`.
- R5: A BAR2 access at or above `mw1_off` targets window index 0 with in-window offset `req_off - mw1_off`. BARs 3, 4 and 5 target window indices 1, 2 and 3 with in-window offset `req_off`. An accepted window access returns region code 5, the in-window offset as local offset, and the index on `dec_win`.
- R6: One cycle after an accepted window access, `xlat_valid` is high and `xlat_addr` equals that window's base plus the in-window offset, using the base held when the request was sampled.
- R7: A window access whose in-window offset is at or above the window's programmed size is an error.
- R8: A window that has not been programmed since reset refuses all accesses with an error.
- R9: BAR numbers 6 and 7 are errors. Windows with index at or above `NUM_WIN` refuse all accesses, and programming writes to those indices have no effect.
- R10: On error, the decoder reports region code 0, local offset 0 and `dec_err` high. With `req_valid` low, it reports region code 0 and no error. In the cycle after an error, an idle cycle or a non-window access, `xlat_valid` is low.
- R11: After reset, `xlat_valid` is low and every window is unprogrammed.
- R12: A write with `cfg_we` high programs base `cfg_base`, size `cfg_size` and the configured state into window `cfg_idx`. Decodes see the new values from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_bar | input | 3 | BAR number of the access |
| req_off | input | OFF_W | Byte offset within the BAR |
| spad_off | input | OFF_W | Start of own scratchpad inside BAR0 |
| spad_count | input | SPC_W | Number of 32-bit scratchpad slots |
| mw1_off | input | OFF_W | Start of window 1 inside BAR2 |
| cfg_we | input | 1 | Program one window |
| cfg_idx | input | 2 | Window index to program |
| cfg_base | input | ADDR_W | Outbound base address |
| cfg_size | input | OFF_W | Window size in bytes |
| dec_region | output | 3 | Region code (0 none, 1 config, 2 own scratchpad, 3 peer scratchpad, 4 doorbell, 5 window) |
| dec_local | output | OFF_W | Offset inside the selected region |
| dec_win | output | 2 | Window index for region code 5 |
| dec_err | output | 1 | Access refused |
| xlat_valid | output | 1 | Translated address valid |
| xlat_addr | output | ADDR_W | Translated outbound address |

## Verification
The region code, local offset, window index and error flag respond within the same cycle as the request and programming values, so the bench compares them half a period after it drives them. The translated address is due one clock edge after the request. The bench's reference model records its expectation at that edge, using the window table as it stood before any programming write on the same edge. It compares the expectation at the following falling edge. A programming write first changes decodes in the cycle after it, and the model updates its table at that same edge.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
   localparam int MAX_WIN = 4;

   typedef enum logic [2:0] {
      RG_NONE      = 3'd0,
      RG_CONFIG    = 3'd1,
      RG_SELF_SPAD = 3'd2,
      RG_PEER_SPAD = 3'd3,
      RG_DOORBELL  = 3'd4,
      RG_WINDOW    = 3'd5
   } region_e;
endpackage

// File: rtl/nbr_win_table.sv
module nbr_win_table
   import nbr_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64,
   parameter int OFF_W   = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [1:0]                        cfg_idx,
   input  logic [ADDR_W-1:0]                 cfg_base,
   input  logic [OFF_W-1:0]                  cfg_size,
   output logic [MAX_WIN-1:0][ADDR_W-1:0]    win_base,
   output logic [MAX_WIN-1:0][OFF_W-1:0]     win_size,
   output logic [MAX_WIN-1:0]                win_valid
);

   for (genvar w = 0; w < MAX_WIN; w++) begin : g_win
      if (w < NUM_WIN) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_base[w]  <= '0;
               win_size[w]  <= '0;
               win_valid[w] <= 1'b0;
            end else if (cfg_we && cfg_idx == 2'(w)) begin
               win_base[w]  <= cfg_base;
               win_size[w]  <= cfg_size;
               win_valid[w] <= 1'b1;
            end
         end
      end else begin : g_absent
         assign win_base[w]  = '0;
         assign win_size[w]  = '0;
         assign win_valid[w] = 1'b0;
      end
   end

   // R9: writes aimed at windows that are not built leave the table alone
   p_absent_write_ignored_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && 32'(cfg_idx) >= NUM_WIN) |=> $stable(win_valid));

endmodule

// File: rtl/nbr_region_decode.sv
module nbr_region_decode
   import nbr_pkg::*;
#(
   parameter int OFF_W = 32,
   parameter int SPC_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [2:0]                     req_bar,
   input  logic [OFF_W-1:0]               req_off,
   input  logic [OFF_W-1:0]               spad_off,
   input  logic [SPC_W-1:0]               spad_count,
   input  logic [OFF_W-1:0]               mw1_off,
   input  logic [MAX_WIN-1:0][OFF_W-1:0]  win_size,
   input  logic [MAX_WIN-1:0]             win_valid,
   output region_e                        region,
   output logic [OFF_W-1:0]               local_off,
   output logic [1:0]                     win_idx,
   output logic                           err
);

   logic [OFF_W-1:0] spad_bytes;
   logic [OFF_W-1:0] spad_rel;
   logic [OFF_W-1:0] mw1_rel;
   logic             is_win;
   logic [1:0]       cand_win;
   logic [OFF_W-1:0] cand_off;

   assign spad_bytes = OFF_W'(spad_count) << 2;
   assign spad_rel   = req_off - spad_off;
   assign mw1_rel    = req_off - mw1_off;

   always_comb begin
      region    = RG_NONE;
      local_off = '0;
      win_idx   = '0;
      err       = 1'b0;
      is_win    = 1'b0;
      cand_win  = '0;
      cand_off  = '0;
      if (req_valid) begin
         case (req_bar)
            3'd0: begin
               if (req_off < spad_off) begin
                  region    = RG_CONFIG;
                  local_off = req_off;
               end else if (spad_rel < spad_bytes) begin
                  region    = RG_SELF_SPAD;
                  local_off = spad_rel;
               end else begin
                  err = 1'b1;
               end
            end
            3'd1: begin
               if (req_off < spad_bytes) begin
                  region    = RG_PEER_SPAD;
                  local_off = req_off;
               end else begin
                  err = 1'b1;
               end
            end
            3'd2: begin
               if (req_off < mw1_off) begin
                  region    = RG_DOORBELL;
                  local_off = req_off;
               end else begin
                  is_win   = 1'b1;
                  cand_win = 2'd0;
                  cand_off = mw1_rel;
               end
            end
            3'd3, 3'd4, 3'd5: begin
               is_win   = 1'b1;
               cand_win = 2'(req_bar - 3'd2);
               cand_off = req_off;
            end
            default: err = 1'b1;
         endcase
         if (is_win) begin
            if (!win_valid[cand_win] || cand_off >= win_size[cand_win]) begin
               err = 1'b1;
            end else begin
               region    = RG_WINDOW;
               local_off = cand_off;
               win_idx   = cand_win;
            end
         end
      end
   end

   // R2: an accepted own-scratchpad access stays inside the slot count
   p_spad_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_SELF_SPAD) |-> (local_off < spad_bytes));
   // R7: an accepted window access stays inside the programmed size
   p_win_bound_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_WINDOW) |-> (local_off < win_size[win_idx]));
   // R8: only programmed windows are ever accepted
   p_win_programmed_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_WINDOW) |-> win_valid[win_idx]);
   // R10: a refused access never carries a region
   p_err_no_region_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (region == RG_NONE && local_off == '0));

endmodule

// File: rtl/nbr_xlat_stage.sv
module nbr_xlat_stage
   import nbr_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              take,
   input  logic [1:0]                        win_idx,
   input  logic [OFF_W-1:0]                  win_off,
   input  logic [MAX_WIN-1:0][ADDR_W-1:0]    win_base,
   output logic                              xlat_valid,
   output logic [ADDR_W-1:0]                 xlat_addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlat_valid <= 1'b0;
         xlat_addr  <= '0;
      end else begin
         xlat_valid <= take;
         if (take) begin
            xlat_addr <= win_base[win_idx] + ADDR_W'(win_off);
         end
      end
   end

   // R6: the translation reflects the base that was in force at the request
   p_xlat_sum_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (xlat_addr == $past(win_base[win_idx]) + ADDR_W'($past(win_off))));

endmodule

// File: rtl/nbr_bar_xlate.sv
module nbr_bar_xlate
   import nbr_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int OFF_W   = 32,
   parameter int ADDR_W  = 64,
   parameter int SPC_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_bar,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [OFF_W-1:0]  spad_off,
   input  logic [SPC_W-1:0]  spad_count,
   input  logic [OFF_W-1:0]  mw1_off,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [OFF_W-1:0]  cfg_size,
   output logic [2:0]        dec_region,
   output logic [OFF_W-1:0]  dec_local,
   output logic [1:0]        dec_win,
   output logic              dec_err,
   output logic              xlat_valid,
   output logic [ADDR_W-1:0] xlat_addr
);

   if (NUM_WIN < 1 || NUM_WIN > MAX_WIN) begin : g_bad_num_win
      $error("NUM_WIN must lie between 1 and 4");
   end
   if (SPC_W + 2 > OFF_W) begin : g_bad_spc_w
      $error("SPC_W too wide for OFF_W");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr_w
      $error("ADDR_W must be at least OFF_W");
   end

   logic [MAX_WIN-1:0][ADDR_W-1:0] win_base;
   logic [MAX_WIN-1:0][OFF_W-1:0]  win_size;
   logic [MAX_WIN-1:0]             win_valid;
   region_e                        region;
   logic                           take;

   nbr_win_table #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_base  (cfg_base),
      .cfg_size  (cfg_size),
      .win_base  (win_base),
      .win_size  (win_size),
      .win_valid (win_valid)
   );

   nbr_region_decode #(.OFF_W(OFF_W), .SPC_W(SPC_W)) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_bar    (req_bar),
      .req_off    (req_off),
      .spad_off   (spad_off),
      .spad_count (spad_count),
      .mw1_off    (mw1_off),
      .win_size   (win_size),
      .win_valid  (win_valid),
      .region     (region),
      .local_off  (dec_local),
      .win_idx    (dec_win),
      .err        (dec_err)
   );

   assign dec_region = region;
   assign take       = (region == RG_WINDOW);

   nbr_xlat_stage #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_xlat (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .win_idx    (dec_win),
      .win_off    (dec_local),
      .win_base   (win_base),
      .xlat_valid (xlat_valid),
      .xlat_addr  (xlat_addr)
   );

   // R10: a translation only follows an accepted window request
   p_xlat_follows_req_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      xlat_valid |-> ($past(req_valid) && !$past(dec_err) && $past(dec_region) == 3'd5));
   // R9: BAR numbers above 5 are always refused
   p_high_bar_refused_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bar > 3'd5) |-> dec_err);

endmodule

// File: tb/nbr_bar_xlate_tb.sv
module nbr_bar_xlate_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NW   = 3;
   localparam int OW   = 32;
   localparam int AW   = 64;
   localparam int SW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_bar = '0;
   logic [OW-1:0] req_off = '0;
   logic [OW-1:0] spad_off = 32'h40;
   logic [SW-1:0] spad_count = 8'd8;
   logic [OW-1:0] mw1_off = 32'h100;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [OW-1:0] cfg_size = '0;
   logic [2:0]    dec_region;
   logic [OW-1:0] dec_local;
   logic [1:0]    dec_win;
   logic          dec_err;
   logic          xlat_valid;
   logic [AW-1:0] xlat_addr;

   nbr_bar_xlate #(.NUM_WIN(NW), .OFF_W(OW), .ADDR_W(AW), .SPC_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bar(req_bar),
      .req_off(req_off), .spad_off(spad_off), .spad_count(spad_count),
      .mw1_off(mw1_off), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_size(cfg_size), .dec_region(dec_region), .dec_local(dec_local),
      .dec_win(dec_win), .dec_err(dec_err), .xlat_valid(xlat_valid),
      .xlat_addr(xlat_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_tag = "R11";
   string xl_tag  = "R11";
   bit    finished = 1'b0;

   logic [AW-1:0] m_base [4];
   logic [OW-1:0] m_size [4];
   bit            m_val  [4];
   bit            exp_xv = 1'b0;
   logic [AW-1:0] exp_xa = '0;

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_base[i] = '0; m_size[i] = '0; m_val[i] = 1'b0;
      end
   end

   task automatic model(output int r, output longint unsigned l, output int w, output bit e);
      longint unsigned off = req_off;
      int  win = -1;
      longint unsigned wo = 0;
      r = 0; l = 0; w = 0; e = 0;
      if (!req_valid) return;
      case (req_bar)
         0: if (off < spad_off) begin r = 1; l = off; end
            else if ((off - spad_off) / 4 < spad_count) begin r = 2; l = off - spad_off; end
            else e = 1;
         1: if (off / 4 < spad_count) begin r = 3; l = off; end else e = 1;
         2: if (off < mw1_off) begin r = 4; l = off; end
            else begin win = 0; wo = off - mw1_off; end
         3, 4, 5: begin win = req_bar - 2; wo = off; end
         default: e = 1;
      endcase
      if (win >= 0) begin
         if (win >= NW || !m_val[win] || wo >= m_size[win]) e = 1;
         else begin r = 5; l = wo; w = win; end
      end
   endtask

   task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // reference model: translation expectation, then table update
   always @(posedge clk) begin
      int r; longint unsigned l; int w; bit e;
      if (!rst_n) begin
         exp_xv = 1'b0; exp_xa = '0;
         for (int i = 0; i < 4; i++) m_val[i] = 1'b0;
      end else begin
         model(r, l, w, e);
         exp_xv = (r == 5);
         if (r == 5) exp_xa = m_base[w] + l;
         if (cfg_we && cfg_idx < NW) begin
            m_base[cfg_idx] = cfg_base;
            m_size[cfg_idx] = cfg_size;
            m_val[cfg_idx]  = 1'b1;
         end
      end
      xl_tag = cur_tag;
   end

   // compare on every falling edge
   always @(negedge clk) begin
      int r; longint unsigned l; int w; bit e;
      if (!finished) begin
         model(r, l, w, e);
         chk(cur_tag, "region", dec_region, r);
         chk(cur_tag, "local", dec_local, l);
         chk(cur_tag, "err", dec_err, e);
         if (r == 5) chk(cur_tag, "win", dec_win, w);
         chk(xl_tag, "xlat_valid", xlat_valid, exp_xv);
         if (exp_xv) chk(xl_tag, "xlat_addr", xlat_addr, exp_xa);
      end
   end

   task automatic req(input logic [2:0] bar, input logic [OW-1:0] off, input string tag);
      @(posedge clk); #1;
      cur_tag = tag; req_valid = 1'b1; req_bar = bar; req_off = off; cfg_we = 1'b0;
   endtask

   task automatic prog(input logic [1:0] idx, input logic [AW-1:0] base,
                       input logic [OW-1:0] size, input string tag);
      @(posedge clk); #1;
      cur_tag = tag; req_valid = 1'b0; cfg_we = 1'b1;
      cfg_idx = idx; cfg_base = base; cfg_size = size;
   endtask

   task automatic idle(input string tag);
      @(posedge clk); #1;
      cur_tag = tag; req_valid = 1'b0; cfg_we = 1'b0;
   endtask

   task automatic wrap_up;
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      wrap_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle("R10");
      // R8 / R11: windows are unprogrammed out of reset
      req(3'd2, 32'h100, "R8");
      req(3'd3, 32'h0, "R11");
      // R1
      req(3'd0, 32'h0, "R1");
      req(3'd0, 32'h3c, "R1");
      // R2
      req(3'd0, 32'h40, "R2");
      req(3'd0, 32'h5c, "R2");
      req(3'd0, 32'h60, "R2");
      // R3
      req(3'd1, 32'h0, "R3");
      req(3'd1, 32'h1c, "R3");
      req(3'd1, 32'h20, "R3");
      // R4
      req(3'd2, 32'h0, "R4");
      req(3'd2, 32'hfc, "R4");
      // R12 / R9 programming
      prog(2'd0, 64'h1_0000_0000, 32'h1000, "R12");
      prog(2'd2, 64'hABCD_0000_0000, 32'h80, "R12");
      prog(2'd3, 64'h5555_0000, 32'h100, "R9");
      // R5 / R6
      req(3'd2, 32'h100, "R5");
      req(3'd2, 32'h10ff, "R6");
      req(3'd2, 32'h1100, "R7");
      req(3'd4, 32'h7f, "R6");
      req(3'd4, 32'h80, "R7");
      req(3'd5, 32'h0, "R9");
      req(3'd3, 32'h4, "R8");
      req(3'd6, 32'h0, "R9");
      req(3'd7, 32'h10, "R9");
      // R12: program window 1 then use it back to back
      prog(2'd1, 64'h2000, 32'h10, "R12");
      req(3'd3, 32'h8, "R5");
      req(3'd3, 32'hf, "R6");
      req(3'd3, 32'h10, "R7");
      // reprogram window 0 with a request in the same cycle
      @(posedge clk); #1;
      cur_tag = "R12"; req_valid = 1'b1; req_bar = 3'd2; req_off = 32'h104;
      cfg_we = 1'b1; cfg_idx = 2'd0; cfg_base = 64'hFFFF_FFFF_0000_0000; cfg_size = 32'h20;
      req(3'd2, 32'h110, "R12");
      req(3'd2, 32'h120, "R7");
      // moved split points
      @(posedge clk); #1;
      spad_off = 32'h80; spad_count = 8'd2; mw1_off = 32'h40;
      cur_tag = "R2"; req_valid = 1'b0;
      req(3'd0, 32'h7c, "R1");
      req(3'd0, 32'h84, "R2");
      req(3'd0, 32'h88, "R2");
      req(3'd1, 32'h8, "R3");
      req(3'd2, 32'h3c, "R4");
      req(3'd2, 32'h44, "R5");
      idle("R10");
      idle("R10");
      @(negedge clk);
      @(posedge clk); #1;
      wrap_up();
   end
endmodule